// File: doc/BRIEF.md
# Serial Command Slave with Frame-Length Checking

This block is the serial front end of an eight-channel output driver controller. An external master selects it with an active-low select line, clocks bits in on the data input and reads a status word back on the data output, least significant bit first in both directions. The slave counts the serial clock rising edges seen during each selection. When the select line is released, the received word is accepted only if that count is a nonzero whole multiple of 16 and the serial clock is low. A run of 32, 48 or more bits is also accepted, so several devices can share one chain. The accepted word splits into eight driver enables and eight open-load diagnostic enables.

All three serial lines are brought into the system clock domain through a short synchronizer. The status word is sampled once, at the moment the select line falls. Its bit 0, the thermal warning, appears on the data output before any serial clock edge arrives, so a master can poll that one bit by pulsing select alone. After the 16 status bits have gone out, the output repeats the input delayed by 16 clocks, which is what a chain of devices needs.

Each accepted word also produces a one-clock acceptance strobe, which the fault logic uses to release latched faults. The command outputs and the strobe have no back-pressure: a consumer must take the strobe in the cycle it appears. The master paces the serial clock, and the slave never stalls it.

Top module: `spi_frame_slave`

## Requirements
- R1: While `rst_n` is low and after it rises, `drv_en_o` and `diag_en_o` are zero, `frame_ok_o` is low and `so_oe_o` is low. The select input is idle high.
- R2: A selection with exactly 16 rising serial clock edges, ended with the serial clock low, writes the received bits to the outputs, first bit received as bit 0. Received bits 7..0 go to `drv_en_o[7:0]` and bits 15..8 go to `diag_en_o[7:0]`.
- R3: A selection whose rising-edge count is 0 or not a multiple of 16 leaves `drv_en_o` and `diag_en_o` unchanged and gives no strobe.
- R4: A selection with 32 rising edges is accepted, and the command holds the last 16 bits received.
- R5: A selection that ends while the serial clock is high is rejected, whatever its bit count, and the command is unchanged.
- R6: The status word is captured when select falls as {supply fault, 0, 0, parallel inputs 8..5, driver faults 8..1, thermal warning}, bit 15 down to bit 0. It is shifted out least significant bit first, one bit per rising serial clock edge. Bit 0 is on `so_o` before the first serial clock.
- R7: In a selection longer than 16 bits, output bit k (for k ≥ 16) equals input bit k−16.
- R8: `so_oe_o` is high only while the synchronized select is low, and `so_o` is low whenever `so_oe_o` is low.
- R9: Each accepted selection raises `frame_ok_o` for exactly one clock, in the same cycle as the command update. The command changes in no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global active-low reset (enable low or supply power-on) |
| csb_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock from master |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for serial data out |
| warn_i | input | 1 | Thermal warning flag |
| supply_flt_i | input | 1 | Supply monitor fault flag |
| par_in_i | input | 4 | Parallel control input levels, channels 5..8 in bits 0..3 |
| drv_flt_i | input | 8 | Per-driver fault flags, driver 1 in bit 0 |
| drv_en_o | output | 8 | Committed driver enables |
| diag_en_o | output | 8 | Committed open-load diagnostic enables |
| frame_ok_o | output | 1 | One-clock strobe on an accepted frame |

## Verification
The bench builds the slave with the default two-stage synchronizer. It runs the serial clock at 16 system clocks per bit, so every serial edge is settled in the system domain well before the next one. These values cover the counts that matter: zero edges, a partial word, one past a word, exactly one word, and two words. They also cover a word that ends with the clock still high, and the 32-bit case shows the chained pass-through. A select pulse with no clock checks that the warning bit is visible at once and that a bare pulse commits nothing.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned MOD_W  = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [7:0] diag_en;
    logic [7:0] drv_en;
  } cmd_t;

  function automatic word_t pack_status(input logic supply, input logic [3:0] par,
                                        input logic [7:0] flt, input logic warn);
    return {supply, 2'b00, par, flt, warn};
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_frame_counter.sv
module spi_frame_counter
  import spi_frame_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic whole
);
  logic [MOD_W-1:0] mod_q;
  logic             any_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
      any_q <= 1'b0;
    end else if (clear) begin
      mod_q <= step ? MOD_W'(1) : '0;
      any_q <= step;
    end else if (step) begin
      mod_q <= mod_q + MOD_W'(1);
      any_q <= 1'b1;
    end
  end

  assign whole = any_q && (mod_q == '0);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_frame_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_val,
  input  logic  shift,
  input  logic  din,
  output word_t word
);
  word_t sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (load)   sr_q <= load_val;
    else if (shift)  sr_q <= {din, sr_q[WORD_W-1:1]};
  end

  assign word = sr_q;
endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
  import spi_frame_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csb_i,
  input  logic       sclk_i,
  input  logic       si_i,
  output logic       so_o,
  output logic       so_oe_o,
  input  logic       warn_i,
  input  logic       supply_flt_i,
  input  logic [3:0] par_in_i,
  input  logic [7:0] drv_flt_i,
  output logic [7:0] drv_en_o,
  output logic [7:0] diag_en_o,
  output logic       frame_ok_o
);
  logic [2:0] sync_q;
  logic cs_s, sck_s, sdi_s;
  logic cs_d, sck_d;
  logic sel_start, sel_end, sck_rise, whole;
  word_t sr_word;
  cmd_t  cmd_q;
  logic  ok_q;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({csb_i, sclk_i, si_i}), .q(sync_q));

  assign {cs_s, sck_s, sdi_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign sel_start = cs_d & ~cs_s;
  assign sel_end   = ~cs_d & cs_s;
  assign sck_rise  = ~sck_d & sck_s & ~cs_s;

  spi_frame_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(sel_start), .step(sck_rise), .whole(whole));

  spi_shifter u_sr (
    .clk(clk), .rst_n(rst_n), .load(sel_start),
    .load_val(pack_status(supply_flt_i, par_in_i, drv_flt_i, warn_i)),
    .shift(sck_rise), .din(sdi_s), .word(sr_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      ok_q <= 1'b0;
      if (sel_end && whole && !sck_s) begin
        cmd_q <= cmd_t'(sr_word);
        ok_q  <= 1'b1;
      end
    end
  end

  assign drv_en_o   = cmd_q.drv_en;
  assign diag_en_o  = cmd_q.diag_en;
  assign frame_ok_o = ok_q;
  assign so_oe_o    = ~cs_s;
  assign so_o       = ~cs_s & sr_word[0];
endmodule

// File: rtl/spi_frame_chk.sv
module spi_frame_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_ok,
  input logic [7:0] drv_en,
  input logic [7:0] diag_en,
  input logic       so,
  input logic       so_oe
);
  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);

  a_r9_cmd_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |-> $stable({diag_en, drv_en}));

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !so_oe |-> !so);

  a_r8_no_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !frame_ok);
endmodule

bind spi_frame_slave spi_frame_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok_o), .drv_en(drv_en_o),
  .diag_en(diag_en_o), .so(so_o), .so_oe(so_oe_o));

// File: tb/sim_spi_frame_slave.sv
module sim_spi_frame_slave;
  localparam int H = 8;
  logic clk = 0;
  logic rst_n = 0;
  logic csb = 1, sclk = 0, si = 0;
  logic warn = 0, sup = 0;
  logic [3:0] par = 0;
  logic [7:0] dflt = 0;
  logic so_o, so_oe_o, frame_ok_o;
  logic [7:0] drv_en_o, diag_en_o;
  int nchk = 0, nfail = 0;
  logic [15:0] expq[$];
  logic prev_ok = 0;
  logic [63:0] got;
  bit done = 0;

  always #2 clk = ~clk;

  spi_frame_slave u0 (
    .clk(clk), .rst_n(rst_n), .csb_i(csb), .sclk_i(sclk), .si_i(si),
    .so_o(so_o), .so_oe_o(so_oe_o), .warn_i(warn), .supply_flt_i(sup),
    .par_in_i(par), .drv_flt_i(dflt), .drv_en_o(drv_en_o),
    .diag_en_o(diag_en_o), .frame_ok_o(frame_ok_o));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [63:0] d, input int n, input bit end_high, output logic [63:0] so_bits);
    so_bits = '0;
    @(negedge clk) csb = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      si = d[i];
      repeat (H) @(negedge clk);
      so_bits[i] = so_o;
      sclk = 1;
      repeat (H) @(negedge clk);
      if (!(end_high && i == n - 1)) sclk = 0;
    end
    repeat (H) @(negedge clk);
    if (n > 0 && n % 16 == 0 && !end_high) expq.push_back(d[n-16 +: 16]);
    csb = 1;
    repeat (2 * H) @(negedge clk);
    sclk = 0;
    repeat (H) @(negedge clk);
  endtask

  // scoreboard monitor: R9 strobe width, R2/R4 committed word
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_ok_o) begin
        chk(!prev_ok, "R9 strobe width", 64'(prev_ok), 64'(0));
        if (expq.size() == 0) chk(1'b0, "R9 unexpected strobe", 64'(1), 64'(0));
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk({diag_en_o, drv_en_o} == e, "R2 R4 committed word", 64'({diag_en_o, drv_en_o}), 64'(e));
        end
      end
      prev_ok = frame_ok_o;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] st;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({diag_en_o, drv_en_o, frame_ok_o, so_oe_o} == 0, "R1 in reset", 64'({diag_en_o, drv_en_o, frame_ok_o, so_oe_o}), 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk({diag_en_o, drv_en_o, frame_ok_o, so_oe_o} == 0, "R1 after reset", 64'({diag_en_o, drv_en_o, frame_ok_o, so_oe_o}), 0);

    // R2 and R6: one word, status read back
    warn = 1; sup = 1; par = 4'b1010; dflt = 8'h96;
    st = {1'b1, 2'b00, 4'b1010, 8'h96, 1'b1};
    xfer(64'hA53C, 16, 0, got);
    chk(drv_en_o == 8'h3C && diag_en_o == 8'hA5, "R2 field split", 64'({diag_en_o, drv_en_o}), 64'hA53C);
    chk(got[15:0] == st, "R6 status word", 64'(got[15:0]), 64'(st));
    // R8 output disabled after deselect
    chk(!so_oe_o && !so_o, "R8 idle output", 64'({so_oe_o, so_o}), 0);

    // R3 partial and overlong counts
    warn = 0; sup = 0; par = 4'b0101; dflt = 8'h01;
    xfer(64'h00FF, 8, 0, got);
    chk({diag_en_o, drv_en_o} == 16'hA53C, "R3 eight bits", 64'({diag_en_o, drv_en_o}), 64'hA53C);
    xfer(64'h1_1234, 17, 0, got);
    chk({diag_en_o, drv_en_o} == 16'hA53C, "R3 seventeen bits", 64'({diag_en_o, drv_en_o}), 64'hA53C);

    // R5 ends with clock high
    xfer(64'h5A5A, 16, 1, got);
    chk({diag_en_o, drv_en_o} == 16'hA53C, "R5 clock high at end", 64'({diag_en_o, drv_en_o}), 64'hA53C);

    // R6 warning visible with no clocks; R3 zero count
    warn = 1;
    @(negedge clk) csb = 0;
    repeat (H) @(negedge clk);
    chk(so_oe_o && so_o, "R6 warning at select", 64'({so_oe_o, so_o}), 64'b11);
    warn = 0;
    csb = 1;
    repeat (3 * H) @(negedge clk);
    chk({diag_en_o, drv_en_o} == 16'hA53C, "R3 zero bits", 64'({diag_en_o, drv_en_o}), 64'hA53C);

    // R4 and R7: two words chained
    st = {1'b0, 2'b00, 4'b0101, 8'h01, 1'b0};
    xfer(64'hC3E1_7E81, 32, 0, got);
    chk({diag_en_o, drv_en_o} == 16'hC3E1, "R4 last word kept", 64'({diag_en_o, drv_en_o}), 64'hC3E1);
    chk(got[31:16] == 16'h7E81, "R7 pass-through", 64'(got[31:16]), 64'h7E81);
    chk(got[15:0] == st, "R6 status second", 64'(got[15:0]), 64'(st));

    // R2 another pattern
    xfer(64'h0F00, 16, 0, got);
    chk(drv_en_o == 8'h00 && diag_en_o == 8'h0F, "R2 second word", 64'({diag_en_o, drv_en_o}), 64'h0F00);

    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R9 all strobes seen", 64'(expq.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule